// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 32-bit processor core that executes one instruction in every clock cycle. It handles word loads and stores, five register-to-register operations (add, subtract, and, or, signed set-less-than), branch-if-equal and an absolute jump. The core holds the program counter, a 32-entry register file, the main decoder, the ALU with its operation decoder, a sign extender and separate adders for the sequential address and the branch target. On a rising clock edge the program counter, a register and a data word are all updated together.

Instruction memory and data memory sit outside the core. The core presents the current program counter as a byte address and expects the instruction word back in the same cycle. It presents the data address, store data and store strobe, and expects read data in the same cycle. The surrounding logic therefore decodes addresses as words, using address bits [7:2] for a 64-word window. A third, independent read port on the register file lets the surrounding logic inspect any register without disturbing execution.

Top module: `unicycle_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0. Outside reset, every instruction that is not a taken branch or a jump advances the program counter by 4.
- R2: Opcode 0 (bits 31..26) is a register operation: rd (bits 15..11) receives rs (bits 25..21) combined with rt (bits 20..16). The operation is chosen by funct (bits 5..0): 32 add, 34 subtract, 36 and, 37 or, 42 set-less-than. An unlisted funct adds.
- R3: Set-less-than compares as signed two's-complement values and writes 1 or 0.
- R4: Opcode 35 loads the word at address rs + sign-extended bits 15..0 into rt.
- R5: Opcode 43 stores rt to address rs + sign-extended bits 15..0, raises the store strobe for that one cycle, and writes no register.
- R6: Opcode 4 compares rs with rt. When they are equal, the next program counter is PC+4 plus the sign-extended offset shifted left by 2. Otherwise it is PC+4, and no register or memory changes.
- R7: Opcode 2 jumps to the upper 4 bits of PC+4 joined with bits 25..0 shifted left by 2, and writes nothing.
- R8: Register 0 always reads as zero, on the datapath and on the inspection port; writes that name it are discarded.
- R9: Any other opcode writes no register and no memory, and only advances the program counter by 4.
- R10: During reset no register and no memory word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (program counter) |
| imem_word | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, write at the next rising edge |
| dmem_re | output | 1 | Load in progress |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |
| peek_sel | input | 5 | Register number for the inspection port |
| peek_val | output | 32 | Content of register peek_sel |

## Verification
Two functions share one clock edge: a load or register operation writes a register, and the next instruction reads that register in the same cycle window. A store can also immediately follow a load from the same word. Random programs chain dependent loads, operations, stores and short forward branches back to back, so every instruction reads what its predecessor wrote a single edge earlier. A bench instruction-level model predicts the final register file and the 64-word memory, which are compared in full after each program ends in a self-jump.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int INSTR_W = 32;

  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    CLS_ADDR  = 2'b00,
    CLS_CMP   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic     dst_rd;
    logic     wr_reg;
    logic     b_imm;
    logic     rd_mem;
    logic     wr_mem;
    logic     wb_mem;
    logic     branch;
    logic     jump;
    alu_cls_e cls;
  } ctrl_t;
endpackage

// File: rtl/cpu_main_decode.sv
module cpu_main_decode
  import cpu_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl     = '0;
    ctrl.cls = CLS_ADDR;
    case (opcode)
      OPC_REG: begin
        ctrl.dst_rd = 1'b1;
        ctrl.wr_reg = 1'b1;
        ctrl.cls    = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.wr_reg = 1'b1;
        ctrl.b_imm  = 1'b1;
        ctrl.rd_mem = 1'b1;
        ctrl.wb_mem = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_imm  = 1'b1;
        ctrl.wr_mem = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.cls    = CLS_CMP;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/cpu_alu_decode.sv
module cpu_alu_decode
  import cpu_pkg::*;
(
  input  alu_cls_e   cls,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);
  always_comb begin
    case (cls)
      CLS_CMP: fn = ALU_SUB;
      CLS_FUNCT: begin
        case (funct)
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_SLT:  fn = ALU_SLT;
          default: fn = ALU_ADD;
        endcase
      end
      default: fn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (fn)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] regs [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) regs[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end
endmodule

// File: rtl/unicycle_core.sv
module unicycle_core
  import cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic [DATA_W-1:0]        imem_addr,
  input  logic [INSTR_W-1:0]       imem_word,
  output logic [DATA_W-1:0]        dmem_addr,
  output logic [DATA_W-1:0]        dmem_wdata,
  output logic                     dmem_we,
  output logic                     dmem_re,
  input  logic [DATA_W-1:0]        dmem_rdata,
  input  logic [$clog2(NREGS)-1:0] peek_sel,
  output logic [DATA_W-1:0]        peek_val
);
  localparam int RAW = $clog2(NREGS);
  localparam int IMM_W = 16;
  localparam logic [DATA_W-1:0] STEP = DATA_W'(4);

  logic [DATA_W-1:0] pc_q, pc_seq, pc_br, pc_jmp, pc_next;
  logic [5:0]        opcode, funct;
  logic [RAW-1:0]    f_rs, f_rt, f_rd, wsel;
  logic [IMM_W-1:0]  imm;
  logic [25:0]       jidx;
  logic [DATA_W-1:0] sext, br_offs, rs_val, rt_val, alu_b, alu_y, wb_val;
  logic              alu_zero, rf_we, take_br;
  ctrl_t             ctrl;
  alu_fn_e           fn;
  logic [2:0][RAW-1:0]    rf_ra;
  logic [2:0][DATA_W-1:0] rf_rd;

  assign opcode = imem_word[31:26];
  assign f_rs   = imem_word[25:21];
  assign f_rt   = imem_word[20:16];
  assign f_rd   = imem_word[15:11];
  assign funct  = imem_word[5:0];
  assign imm    = imem_word[15:0];
  assign jidx   = imem_word[25:0];

  cpu_main_decode u_dec (.opcode(opcode), .ctrl(ctrl));
  cpu_alu_decode  u_adec (.cls(ctrl.cls), .funct(funct), .fn(fn));

  assign rf_ra = {peek_sel, f_rt, f_rs};
  assign wsel  = ctrl.dst_rd ? f_rd : f_rt;
  assign rf_we = ctrl.wr_reg & ~rst;

  cpu_regfile #(.W(DATA_W), .DEPTH(NREGS), .NRD(3)) u_rf (
    .clk(clk), .we(rf_we), .waddr(wsel), .wdata(wb_val),
    .raddr(rf_ra), .rdata(rf_rd)
  );
  assign rs_val   = rf_rd[0];
  assign rt_val   = rf_rd[1];
  assign peek_val = rf_rd[2];

  assign sext    = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign br_offs = {sext[DATA_W-3:0], 2'b00};
  assign alu_b   = ctrl.b_imm ? sext : rt_val;

  cpu_alu #(.W(DATA_W)) u_alu (
    .fn(fn), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_zero)
  );

  assign wb_val = ctrl.wb_mem ? dmem_rdata : alu_y;

  assign pc_seq  = pc_q + STEP;
  assign pc_br   = pc_seq + br_offs;
  assign pc_jmp  = {pc_seq[DATA_W-1:DATA_W-4], jidx, 2'b00};
  assign take_br = ctrl.branch & alu_zero;

  always_comb begin
    if (ctrl.jump)    pc_next = pc_jmp;
    else if (take_br) pc_next = pc_br;
    else              pc_next = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctrl.wr_mem & ~rst;
  assign dmem_re    = ctrl.rd_mem & ~rst;

  AST_PC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    imem_addr[1:0] == 2'b00); // R1
  AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.branch && !ctrl.jump) |=> imem_addr == $past(imem_addr) + STEP); // R1
  AST_BR_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && rs_val == rt_val) |=> imem_addr == $past(imem_addr) + STEP + $past(br_offs)); // R6
  AST_BR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && rs_val != rt_val) |=> imem_addr == $past(imem_addr) + STEP); // R6
  AST_BR_QUIET: assert property (@(posedge clk) disable iff (rst)
    ctrl.branch |-> (!rf_we && !dmem_we)); // R6
  AST_JUMP_TGT: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> imem_addr[27:0] == {$past(jidx), 2'b00}); // R7
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
    (f_rs == '0) |-> (rs_val == '0)); // R8
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !rf_we); // R5
  AST_CTRL_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.rd_mem, ctrl.wr_mem, ctrl.branch, ctrl.jump})); // R9
  AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (rst)
    (opcode != OPC_REG && opcode != OPC_LOAD && opcode != OPC_STORE &&
     opcode != OPC_BEQ && opcode != OPC_JUMP) |-> (!rf_we && !dmem_we)); // R9
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |-> (!rf_we && !dmem_we)); // R10
endmodule

// File: tb/unicycle_core_test.sv
module unicycle_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_word, dmem_addr, dmem_wdata, dmem_rdata, peek_val;
  logic        dmem_we, dmem_re;
  logic [4:0]  peek_sel = '0;

  logic [31:0] prog [64];
  logic [31:0] dmem [64];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc, m_first_pc;
  int          m_steps;
  int          checks = 0;
  int          fails  = 0;

  always #2 clk = ~clk;

  unicycle_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_word(imem_word),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata), .peek_sel(peek_sel),
    .peek_val(peek_val)
  );

  assign imem_word  = prog[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(logic [5:0] fn, int rd, int rs, int rt);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rt, int rs, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int idx);
    return {6'd2, 26'(idx)};
  endfunction
  function automatic logic [31:0] sx(logic [31:0] ins);
    return {{16{ins[15]}}, ins[15:0]};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Instruction-level model of the requirements
  task automatic model_run();
    logic [31:0] ins, a, pc4;
    m_pc = 0;
    m_steps = 0;
    m_first_pc = 0;
    for (int i = 0; i < 64; i++) m_mem[i] = dmem[i];
    for (int s = 0; s < 300; s++) begin
      ins = prog[m_pc[7:2]];
      if (ins[31:26] == 6'd2 && {ins[25:0], 2'b00} == m_pc[27:0]) break;
      pc4 = m_pc + 4;
      a = m_reg[ins[25:21]] + sx(ins);
      case (ins[31:26])
        6'd0: begin
          logic [31:0] x, y, r;
          x = m_reg[ins[25:21]];
          y = m_reg[ins[20:16]];
          case (ins[5:0])
            6'd34:   r = x - y;
            6'd36:   r = x & y;
            6'd37:   r = x | y;
            6'd42:   r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: r = x + y;
          endcase
          if (ins[15:11] != 0) m_reg[ins[15:11]] = r;
          m_pc = pc4;
        end
        6'd35: begin
          if (ins[20:16] != 0) m_reg[ins[20:16]] = m_mem[a[7:2]];
          m_pc = pc4;
        end
        6'd43: begin
          m_mem[a[7:2]] = m_reg[ins[20:16]];
          m_pc = pc4;
        end
        6'd4: m_pc = (m_reg[ins[25:21]] == m_reg[ins[20:16]]) ? pc4 + {sx(ins)[29:0], 2'b00} : pc4;
        6'd2: m_pc = {pc4[31:28], ins[25:0], 2'b00};
        default: m_pc = pc4;
      endcase
      if (s == 0) m_first_pc = m_pc;
      m_steps++;
    end
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) prog[i] = 32'd0;
  endtask

  task automatic run_prog(string tag);
    model_run();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R1", "pc after reset", imem_addr, 32'd0);
    check("R10", "no store under reset", {31'd0, dmem_we}, 32'd0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", "pc after first instruction", imem_addr, m_first_pc);
    repeat (m_steps + 3) @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < 32; r++) begin
      peek_sel = 5'(r);
      #1;
      check(tag, $sformatf("reg %0d", r), peek_val, m_reg[r]);
    end
    for (int w = 0; w < 64; w++) check(tag, $sformatf("mem %0d", w), dmem[w], m_mem[w]);
  endtask

  task automatic gen_random();
    int n;
    logic [5:0] fns [5];
    fns = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd42};
    begin_prog();
    for (int i = 0; i < 64; i++) dmem[i] = $urandom;
    dmem[$urandom_range(0, 63)] = 32'h8000_0000;
    for (int r = 1; r <= 8; r++) prog[r-1] = enc_i(6'd35, r, 0, 4 * $urandom_range(0, 63));
    n = 8;
    for (int k = 0; k < 20; k++) begin
      int kind;
      kind = $urandom_range(0, 9);
      if (kind <= 4)
        prog[n] = enc_r(fns[$urandom_range(0, 4)], $urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 12));
      else if (kind == 5)
        prog[n] = enc_i(6'd43, $urandom_range(0, 12), 0, 4 * $urandom_range(0, 63));
      else if (kind == 6)
        prog[n] = enc_i(6'd35, $urandom_range(0, 12), 0, 4 * $urandom_range(0, 63));
      else if (kind == 7 && n + 3 <= 28)
        prog[n] = enc_i(6'd4, $urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(1, 2));
      else if (kind == 8)
        prog[n] = {6'(($urandom_range(0, 1) == 0) ? 8 : 63), 26'($urandom)};
      else
        prog[n] = enc_r(6'd32, $urandom_range(1, 12), $urandom_range(0, 12), 0);
      n++;
    end
    prog[n] = enc_j(n);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    for (int i = 0; i < 64; i++) begin
      dmem[i] = 32'd0;
      prog[i] = 32'd0;
    end
    void'($urandom(32'h1F2E3D4C));

    // R2 R3: signed compare with a negative operand, all functs
    begin_prog();
    dmem[0] = 32'hFFFF_FFF0;
    dmem[1] = 32'd5;
    prog[0] = enc_i(6'd35, 1, 0, 0);
    prog[1] = enc_i(6'd35, 2, 0, 4);
    prog[2] = enc_r(6'd42, 3, 1, 2);
    prog[3] = enc_r(6'd42, 4, 2, 1);
    prog[4] = enc_r(6'd34, 5, 2, 1);
    prog[5] = enc_r(6'd36, 6, 1, 2);
    prog[6] = enc_r(6'd37, 7, 1, 2);
    prog[7] = enc_r(6'd32, 8, 1, 2);
    prog[8] = enc_j(8);
    run_prog("R3");

    // R4 R5: negative offsets and load-to-store back to back
    begin_prog();
    dmem[0]  = 32'h0000_0100;
    dmem[63] = 32'hCAFE_0001;
    prog[0] = enc_i(6'd35, 9, 0, 0);
    prog[1] = enc_i(6'd35, 10, 9, -4);
    prog[2] = enc_i(6'd43, 10, 9, -8);
    prog[3] = enc_i(6'd43, 1, 0, 8);
    prog[4] = enc_j(4);
    run_prog("R4");

    // R6: taken branch skips, untaken falls through
    begin_prog();
    dmem[2] = 32'd77;
    prog[0] = enc_i(6'd35, 1, 0, 8);
    prog[1] = enc_i(6'd4, 1, 1, 1);
    prog[2] = enc_r(6'd32, 11, 1, 1);
    prog[3] = enc_i(6'd4, 2, 1, 1);
    prog[4] = enc_r(6'd32, 12, 1, 1);
    prog[5] = enc_j(5);
    run_prog("R6");

    // R7: jump over writes
    begin_prog();
    prog[0] = enc_j(3);
    prog[1] = enc_r(6'd32, 13, 1, 1);
    prog[2] = enc_i(6'd43, 1, 0, 12);
    prog[3] = enc_r(6'd37, 14, 1, 2);
    prog[4] = enc_j(4);
    run_prog("R7");

    // R8: register 0 stays zero
    begin_prog();
    dmem[5] = 32'h1234_5678;
    prog[0] = enc_i(6'd35, 0, 0, 20);
    prog[1] = enc_r(6'd32, 0, 1, 2);
    prog[2] = enc_r(6'd32, 15, 0, 1);
    prog[3] = enc_j(3);
    run_prog("R8");

    // R9: unknown opcodes are no-ops
    begin_prog();
    prog[0] = {6'd8, 5'd1, 5'd16, 16'h7FFF};
    prog[1] = {6'd63, 26'h3FF_FFFF};
    prog[2] = {6'd13, 5'd2, 5'd17, 16'h0004};
    prog[3] = enc_j(3);
    run_prog("R9");

    // R2 R5: random programs with dependent back-to-back instructions
    for (int t = 0; t < 24; t++) begin
      gen_random();
      run_prog("R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule